// File: doc/BRIEF.md
# Region-Based Memory Protection Checker

This block decides whether each bus access may proceed, based on sixteen programmable address windows. Every window has a power-of-two size, is split into eight equal parts that can be removed one by one, and carries a 3-bit permission code, an execute-never flag and a set of memory-type bits. An access supplies its address, privilege level, direction and whether it is an instruction fetch. One clock later the block returns allow or fault and, for allowed accesses, the memory type of the winning window.

Software sets the block up through a small write port with four targets: a control word, a window index, a window base and a window attribute word. The usual sequence is to clear the enable bit, select a window, write its base and then its attributes, repeat for each window, and finally set enable again. Window 0 is normally set up as a catch-all covering the whole 4 GB space with no access, so that any address not claimed by a higher window faults.

Top module: `region_guard`

## Requirements
- R1: After reset, protection is off, every window is disabled, and rsp_valid, rsp_allow and rsp_fault are all 0.
- R2: Results are registered. rsp_valid is 1 exactly in the cycle after a cycle with acc_valid=1. In a cycle after acc_valid=0, rsp_valid, rsp_allow and rsp_fault are all 0.
- R3: Writing cfg_sel=0 loads the control word: bit 0 turns protection on and bit 1 keeps it on for accesses with acc_handler=1. Protection is bypassed when bit 0 is clear, or when acc_handler=1 and bit 1 is clear. A bypassed access is allowed with all memory-type outputs at 0 and no fault.
- R4: cfg_sel=1 stores the window index from cfg_wdata[3:0]. cfg_sel=2 writes the base of the selected window, keeping bits [31:5]. cfg_sel=3 writes its attribute word. Each write takes effect from the next cycle and leaves the other windows unchanged.
- R5: In the attribute word, bit 0 enables the window and bits [5:1] hold SIZE. The window spans 2^(SIZE+1) bytes and matches when address bits [31:SIZE+1] equal the same bits of the base. A window that is disabled, or that has SIZE below 4, never matches.
- R6: Attribute bits [15:8] remove eighths of a window. Bit 8+k removes eighth k, which is selected by address bits [SIZE:SIZE-2]. A removed eighth does not match.
- R7: If several windows match, the one with the highest index alone decides the result. A window whose eighth is removed does not take part, so a lower window can decide instead.
- R8: The permission code in attribute bits [26:24] is decoded as follows. 000 and 100 allow nothing. 001 allows privileged read/write only. 010 allows privileged read/write and unprivileged read. 011 allows read/write for both levels. 101 allows privileged read only. 110 and 111 allow read only for both levels.
- R9: When attribute bit 28 (execute-never) is set, an instruction fetch that hits the window is denied. Data reads are still decided by the permission code.
- R10: An allowed protected access outputs TEX from attribute bits [21:19], shareable from bit 18, cacheable from bit 17 and bufferable from bit 16. A denied access outputs all memory-type bits as 0.
- R11: With protection active, an access that no window matches, or that its winning window refuses, is denied. rsp_fault is then 1 for that access's single result cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_we | input | 1 | Configuration write strobe |
| cfg_sel | input | 2 | Write target: 0 control, 1 window index, 2 base, 3 attributes |
| cfg_wdata | input | 32 | Configuration write data |
| acc_valid | input | 1 | An access is presented this cycle |
| acc_addr | input | 32 | Access byte address |
| acc_priv | input | 1 | Access is privileged |
| acc_write | input | 1 | Access is a write |
| acc_fetch | input | 1 | Access is an instruction fetch |
| acc_handler | input | 1 | Access comes from fault or NMI handler context |
| rsp_valid | output | 1 | Result of the previous cycle's access |
| rsp_allow | output | 1 | Access permitted |
| rsp_fault | output | 1 | Access denied (one cycle per denied access) |
| rsp_tex | output | 3 | Memory-type extension bits of the winning window |
| rsp_shareable | output | 1 | Shareable attribute |
| rsp_cacheable | output | 1 | Cacheable attribute |
| rsp_bufferable | output | 1 | Bufferable attribute |

## Verification
The assertions cover the properties that hold on every cycle whatever the configuration. Result timing follows the access strobe, and idle cycles stay quiet. Allow and fault are mutually exclusive whenever a result is valid, a denied result carries no memory type, and a disabled block allows everything. The bench scenarios are needed for the behaviour that depends on programmed windows. This includes size and alignment matching, removed eighths handing control to a lower window, the highest-index rule, the permission and execute-never decode, and the handler-context bypass.

// File: rtl/rg_pkg.sv
package rg_pkg;

  localparam int ADDR_W = 32;
  localparam int MIN_SIZE = 4;

  typedef enum logic [1:0] {
    CSR_CTRL = 2'd0,
    CSR_RNUM = 2'd1,
    CSR_BASE = 2'd2,
    CSR_ATTR = 2'd3
  } csr_sel_e;

  typedef struct packed {
    logic       xn;
    logic [2:0] ap;
    logic [2:0] tex;
    logic       shr;
    logic       cch;
    logic       buf_;
    logic [7:0] srd;
    logic [4:0] size;
    logic       en;
  } rattr_t;

  function automatic rattr_t unpack_attr(input logic [31:0] w);
    rattr_t a;
    a.xn   = w[28];
    a.ap   = w[26:24];
    a.tex  = w[21:19];
    a.shr  = w[18];
    a.cch  = w[17];
    a.buf_ = w[16];
    a.srd  = w[15:8];
    a.size = w[5:1];
    a.en   = w[0];
    return a;
  endfunction

  function automatic logic ap_permits(input logic [2:0] ap, input logic priv,
                                      input logic wr);
    logic ok;
    case (ap)
      3'b001:         ok = priv;
      3'b010:         ok = priv || !wr;
      3'b011:         ok = 1'b1;
      3'b101:         ok = priv && !wr;
      3'b110, 3'b111: ok = !wr;
      default:        ok = 1'b0;
    endcase
    return ok;
  endfunction

endpackage

// File: rtl/rg_regfile.sv
module rg_regfile
  import rg_pkg::*;
#(
  parameter int NREG  = 16,
  parameter int IDX_W = $clog2(NREG)
) (
  input  logic                          clk,
  input  logic                          rst,
  input  logic                          cfg_we,
  input  logic [1:0]                    cfg_sel,
  input  logic [31:0]                   cfg_wdata,
  output logic                          ctl_enable,
  output logic                          ctl_handler,
  output logic [NREG-1:0][ADDR_W-1:0]   base_q,
  output rattr_t [NREG-1:0]             attr_q
);

  logic [IDX_W-1:0] rnum_q;
  logic             unused_wdata;

  assign unused_wdata = ^cfg_wdata;

  always_ff @(posedge clk) begin
    if (rst) begin
      ctl_enable  <= 1'b0;
      ctl_handler <= 1'b0;
      rnum_q      <= '0;
    end else if (cfg_we) begin
      if (cfg_sel == CSR_CTRL) begin
        ctl_enable  <= cfg_wdata[0];
        ctl_handler <= cfg_wdata[1];
      end
      if (cfg_sel == CSR_RNUM) rnum_q <= cfg_wdata[IDX_W-1:0];
    end
  end

  for (genvar i = 0; i < NREG; i++) begin : g_slot
    logic hit_sel;
    assign hit_sel = cfg_we && (rnum_q == IDX_W'(i));

    always_ff @(posedge clk) begin
      if (rst) begin
        base_q[i] <= '0;
        attr_q[i] <= '0;
      end else begin
        if (hit_sel && cfg_sel == CSR_BASE) base_q[i] <= {cfg_wdata[31:5], 5'b0};
        if (hit_sel && cfg_sel == CSR_ATTR) attr_q[i] <= unpack_attr(cfg_wdata);
      end
    end
  end

endmodule

// File: rtl/rg_match.sv
module rg_match
  import rg_pkg::*;
#(
  parameter int NREG = 16
) (
  input  logic [ADDR_W-1:0]             addr,
  input  logic [NREG-1:0][ADDR_W-1:0]   base_q,
  input  rattr_t [NREG-1:0]             attr_q,
  output logic [NREG-1:0]               hit
);

  for (genvar i = 0; i < NREG; i++) begin : g_win
    logic [32:0]       span;
    logic [32:0]       low_bits;
    logic [ADDR_W-1:0] keep_mask;
    logic [4:0]        sub_shift;
    logic [2:0]        sub_idx;
    logic              size_ok;
    logic              unused_fields;

    assign span      = 33'd1 << (6'(attr_q[i].size) + 6'd1);
    assign low_bits  = span - 33'd1;
    assign keep_mask = ~low_bits[ADDR_W-1:0];
    assign sub_shift = attr_q[i].size - 5'd2;
    assign sub_idx   = 3'(addr >> sub_shift);
    assign size_ok   = attr_q[i].size >= 5'(MIN_SIZE);

    assign hit[i] = attr_q[i].en && size_ok &&
                    (((addr ^ base_q[i]) & keep_mask) == '0) &&
                    !attr_q[i].srd[sub_idx];

    assign unused_fields = ^{attr_q[i].xn, attr_q[i].ap, attr_q[i].tex,
                             attr_q[i].shr, attr_q[i].cch, attr_q[i].buf_,
                             low_bits[32]};
  end

endmodule

// File: rtl/rg_pick.sv
module rg_pick
  import rg_pkg::*;
#(
  parameter int NREG = 16
) (
  input  logic [NREG-1:0]    hit,
  input  rattr_t [NREG-1:0]  attr_q,
  output logic               found,
  output rattr_t             winner
);

  always_comb begin
    found  = 1'b0;
    winner = '0;
    for (int i = 0; i < NREG; i++) begin
      if (hit[i]) begin
        found  = 1'b1;
        winner = attr_q[i];
      end
    end
  end

endmodule

// File: rtl/region_guard.sv
module region_guard
  import rg_pkg::*;
#(
  parameter int NREG = 16
) (
  input  logic        clk,
  input  logic        rst,
  input  logic        cfg_we,
  input  logic [1:0]  cfg_sel,
  input  logic [31:0] cfg_wdata,
  input  logic        acc_valid,
  input  logic [31:0] acc_addr,
  input  logic        acc_priv,
  input  logic        acc_write,
  input  logic        acc_fetch,
  input  logic        acc_handler,
  output logic        rsp_valid,
  output logic        rsp_allow,
  output logic        rsp_fault,
  output logic [2:0]  rsp_tex,
  output logic        rsp_shareable,
  output logic        rsp_cacheable,
  output logic        rsp_bufferable
);

  localparam int IDX_W = $clog2(NREG);

  logic                        ctl_enable;
  logic                        ctl_handler;
  logic [NREG-1:0][ADDR_W-1:0] base_q;
  rattr_t [NREG-1:0]           attr_q;
  logic [NREG-1:0]             hit;
  logic                        found;
  rattr_t                      winner;
  logic                        guarded;
  logic                        permit;
  logic                        unused_win;

  rg_regfile #(.NREG(NREG), .IDX_W(IDX_W)) u_regs (
    .clk(clk), .rst(rst), .cfg_we(cfg_we), .cfg_sel(cfg_sel),
    .cfg_wdata(cfg_wdata), .ctl_enable(ctl_enable), .ctl_handler(ctl_handler),
    .base_q(base_q), .attr_q(attr_q)
  );

  rg_match #(.NREG(NREG)) u_match (
    .addr(acc_addr), .base_q(base_q), .attr_q(attr_q), .hit(hit)
  );

  rg_pick #(.NREG(NREG)) u_pick (
    .hit(hit), .attr_q(attr_q), .found(found), .winner(winner)
  );

  assign guarded = ctl_enable && (!acc_handler || ctl_handler);
  assign permit  = !guarded ||
                   (found && ap_permits(winner.ap, acc_priv, acc_write) &&
                    !(acc_fetch && winner.xn));
  assign unused_win = ^{winner.srd, winner.size, winner.en};

  always_ff @(posedge clk) begin
    if (rst) begin
      rsp_valid      <= 1'b0;
      rsp_allow      <= 1'b0;
      rsp_fault      <= 1'b0;
      rsp_tex        <= '0;
      rsp_shareable  <= 1'b0;
      rsp_cacheable  <= 1'b0;
      rsp_bufferable <= 1'b0;
    end else begin
      rsp_valid <= acc_valid;
      rsp_allow <= acc_valid && permit;
      rsp_fault <= acc_valid && !permit;
      if (acc_valid && guarded && permit) begin
        rsp_tex        <= winner.tex;
        rsp_shareable  <= winner.shr;
        rsp_cacheable  <= winner.cch;
        rsp_bufferable <= winner.buf_;
      end else begin
        rsp_tex        <= '0;
        rsp_shareable  <= 1'b0;
        rsp_cacheable  <= 1'b0;
        rsp_bufferable <= 1'b0;
      end
    end
  end

endmodule

// File: rtl/rg_checker.sv
module rg_checker (
  input logic       clk,
  input logic       rst,
  input logic       acc_valid,
  input logic       prot_on,
  input logic       rsp_valid,
  input logic       rsp_allow,
  input logic       rsp_fault,
  input logic [2:0] rsp_tex,
  input logic       rsp_shareable,
  input logic       rsp_cacheable,
  input logic       rsp_bufferable
);

  // R2
  valid_follow_chk: assert property (@(posedge clk) disable iff (rst)
    acc_valid |=> rsp_valid);

  // R2
  idle_quiet_chk: assert property (@(posedge clk) disable iff (rst)
    !acc_valid |=> (!rsp_valid && !rsp_allow && !rsp_fault));

  // R11
  one_verdict_chk: assert property (@(posedge clk) disable iff (rst)
    rsp_valid |-> (rsp_allow != rsp_fault));

  // R10
  deny_no_type_chk: assert property (@(posedge clk) disable iff (rst)
    !rsp_allow |-> ({rsp_tex, rsp_shareable, rsp_cacheable, rsp_bufferable} == 6'd0));

  // R3
  bypass_allow_chk: assert property (@(posedge clk) disable iff (rst)
    (acc_valid && !prot_on) |=> (rsp_allow && !rsp_fault));

endmodule

bind region_guard rg_checker u_rg_checker (
  .clk(clk), .rst(rst), .acc_valid(acc_valid), .prot_on(ctl_enable),
  .rsp_valid(rsp_valid), .rsp_allow(rsp_allow), .rsp_fault(rsp_fault),
  .rsp_tex(rsp_tex), .rsp_shareable(rsp_shareable),
  .rsp_cacheable(rsp_cacheable), .rsp_bufferable(rsp_bufferable)
);

// File: tb/test_region_guard.sv
`timescale 1ns/1ps
module test_region_guard;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        cfg_we = 1'b0;
  logic [1:0]  cfg_sel = '0;
  logic [31:0] cfg_wdata = '0;
  logic        acc_valid = 1'b0;
  logic [31:0] acc_addr = '0;
  logic        acc_priv = 1'b0;
  logic        acc_write = 1'b0;
  logic        acc_fetch = 1'b0;
  logic        acc_handler = 1'b0;
  logic        rsp_valid, rsp_allow, rsp_fault;
  logic [2:0]  rsp_tex;
  logic        rsp_shareable, rsp_cacheable, rsp_bufferable;

  int n_checks = 0;
  int n_fail   = 0;
  int cycles   = 0;

  always #2.5 clk = ~clk;

  region_guard i_region_guard (
    .clk(clk), .rst(rst), .cfg_we(cfg_we), .cfg_sel(cfg_sel),
    .cfg_wdata(cfg_wdata), .acc_valid(acc_valid), .acc_addr(acc_addr),
    .acc_priv(acc_priv), .acc_write(acc_write), .acc_fetch(acc_fetch),
    .acc_handler(acc_handler), .rsp_valid(rsp_valid), .rsp_allow(rsp_allow),
    .rsp_fault(rsp_fault), .rsp_tex(rsp_tex), .rsp_shareable(rsp_shareable),
    .rsp_cacheable(rsp_cacheable), .rsp_bufferable(rsp_bufferable)
  );

  typedef struct packed {
    logic [31:0] addr;
    logic        priv;
    logic        wr;
    logic        fe;
    logic        ok;
    logic [5:0]  mt;   // {tex, s, c, b}
  } vec_t;

  localparam int NV = 22;
  localparam vec_t VEC [NV] = '{
    '{32'h0000_1000, 1'b0, 1'b0, 1'b0, 1'b1, 6'b001_000}, // R8 011 user read
    '{32'h0000_1000, 1'b0, 1'b1, 1'b0, 1'b1, 6'b001_000}, // R8 011 user write
    '{32'h0000_1000, 1'b0, 1'b0, 1'b1, 1'b1, 6'b001_000}, // R9 fetch, XN clear
    '{32'h0001_0000, 1'b1, 1'b0, 1'b0, 1'b0, 6'b000_000}, // R5 just past 64 KB
    '{32'h0041_2340, 1'b0, 1'b0, 1'b0, 1'b1, 6'b001_011}, // R10 read-only window
    '{32'h0041_2340, 1'b1, 1'b1, 1'b0, 1'b0, 6'b000_000}, // R8 110 write denied
    '{32'h0060_0000, 1'b1, 1'b0, 1'b0, 1'b0, 6'b000_000}, // R5 past 2 MB window
    '{32'h2000_4000, 1'b0, 1'b1, 1'b0, 1'b1, 6'b000_100}, // R6 eighth 1 live
    '{32'h2000_4000, 1'b1, 1'b0, 1'b1, 1'b0, 6'b000_000}, // R9 XN fetch
    '{32'h2001_8000, 1'b1, 1'b0, 1'b0, 1'b0, 6'b000_000}, // R6 eighth 6 removed
    '{32'h2001_7FFC, 1'b1, 1'b0, 1'b0, 1'b1, 6'b000_100}, // R6 eighth 5 live
    '{32'h2000_0010, 1'b1, 1'b1, 1'b0, 1'b1, 6'b000_010}, // R7 window 4 wins
    '{32'h2000_0010, 1'b0, 1'b0, 1'b0, 1'b0, 6'b000_000}, // R7 higher refuses
    '{32'h4000_001C, 1'b0, 1'b0, 1'b0, 1'b1, 6'b000_000}, // R8 010 user read
    '{32'h4000_001C, 1'b0, 1'b1, 1'b0, 1'b0, 6'b000_000}, // R8 010 user write
    '{32'h4000_001C, 1'b1, 1'b1, 1'b0, 1'b1, 6'b000_000}, // R8 010 priv write
    '{32'h4000_0020, 1'b1, 1'b0, 1'b0, 1'b0, 6'b000_000}, // R5 past 32 B
    '{32'h5000_0000, 1'b1, 1'b0, 1'b0, 1'b0, 6'b000_000}, // R5 SIZE 3 no match
    '{32'h6000_03FC, 1'b1, 1'b0, 1'b0, 1'b1, 6'b000_000}, // R8 101 priv read
    '{32'h6000_03FC, 1'b0, 1'b0, 1'b0, 1'b0, 6'b000_000}, // R8 101 user read
    '{32'h6000_0000, 1'b1, 1'b1, 1'b0, 1'b0, 6'b000_000}, // R8 101 priv write
    '{32'hFFFF_FFF0, 1'b1, 1'b0, 1'b0, 1'b0, 6'b000_000}  // R11 background
  };

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_checks++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic cfg(input logic [1:0] sel, input logic [31:0] data);
    @(negedge clk);
    cfg_we = 1'b1; cfg_sel = sel; cfg_wdata = data;
    @(negedge clk);
    cfg_we = 1'b0;
  endtask

  task automatic prog(input int idx, input logic [31:0] base, input logic [31:0] attr);
    cfg(2'd1, 32'(idx));
    cfg(2'd2, base);
    cfg(2'd3, attr);
  endtask

  task automatic access(input logic [31:0] a, input logic p, input logic w,
                        input logic f, input logic h);
    @(negedge clk);
    acc_valid = 1'b1; acc_addr = a; acc_priv = p; acc_write = w;
    acc_fetch = f; acc_handler = h;
    @(negedge clk);
    acc_valid = 1'b0;
  endtask

  function automatic logic [5:0] mtype();
    return {rsp_tex, rsp_shareable, rsp_cacheable, rsp_bufferable};
  endfunction

  task automatic finish_run();
    $display("  %0d/%0d checks passed", n_checks - n_fail, n_checks);
    $finish;
  endtask

  always @(posedge clk) begin
    cycles++;
    if (cycles > 20000) begin
      n_checks++;
      n_fail++;
      $display("FAIL watchdog R2: actual=%0d cycles expected<=20000", cycles);
      finish_run();
    end
  end

  initial begin
    repeat (4) @(negedge clk);
    // R1 reset state
    check("R1 valid after reset", 32'(rsp_valid), 0);
    check("R1 allow after reset", 32'(rsp_allow), 0);
    check("R1 fault after reset", 32'(rsp_fault), 0);
    rst = 1'b0;

    // R1 R3 protection off after reset: everything allowed, no type
    access(32'hFFFF_FFF0, 1'b0, 1'b1, 1'b1, 1'b0);
    check("R3 off allow", 32'(rsp_allow), 1);
    check("R3 off fault", 32'(rsp_fault), 0);
    check("R3 off type", 32'(mtype()), 0);

    prog(0, 32'h0000_0000, 32'h1000_003F);
    prog(1, 32'h0000_0000, 32'h0308_001F);
    prog(2, 32'h0040_0000, 32'h060B_0029);
    prog(3, 32'h2000_0000, 32'h1304_C021);
    prog(4, 32'h2000_0000, 32'h0102_001B);
    prog(5, 32'h4000_0000, 32'h0200_0009);
    prog(6, 32'h5000_0000, 32'h0300_0007);
    prog(7, 32'h6000_0000, 32'h0500_0013);
    prog(8, 32'h0000_0000, 32'h0300_003E);   // R5 disabled window, would allow all

    // R3 programmed but not enabled: still bypassed with zero type
    access(32'h0041_2340, 1'b0, 1'b0, 1'b0, 1'b0);
    check("R3 disabled allow", 32'(rsp_allow), 1);
    check("R3 disabled type", 32'(mtype()), 0);

    cfg(2'd0, 32'h3);
    for (int i = 0; i < NV; i++) begin
      access(VEC[i].addr, VEC[i].priv, VEC[i].wr, VEC[i].fe, 1'b0);
      check($sformatf("R8 vec%0d allow", i), 32'(rsp_allow), 32'(VEC[i].ok));
      check($sformatf("R11 vec%0d fault", i), 32'(rsp_fault), 32'(!VEC[i].ok));
      check($sformatf("R10 vec%0d type", i), 32'(mtype()), 32'(VEC[i].mt));
      check($sformatf("R2 vec%0d valid", i), 32'(rsp_valid), 1);
    end

    // R11 R2 fault lasts one cycle
    access(32'hFFFF_FFF0, 1'b1, 1'b0, 1'b0, 1'b0);
    check("R11 fault pulse", 32'(rsp_fault), 1);
    @(negedge clk);
    check("R11 fault cleared", 32'(rsp_fault), 0);
    check("R2 valid cleared", 32'(rsp_valid), 0);

    // R3 handler context without keep bit bypasses
    cfg(2'd0, 32'h1);
    access(32'hFFFF_FFF0, 1'b1, 1'b0, 1'b0, 1'b1);
    check("R3 handler bypass allow", 32'(rsp_allow), 1);
    check("R3 handler bypass type", 32'(mtype()), 0);
    access(32'hFFFF_FFF0, 1'b1, 1'b0, 1'b0, 1'b0);
    check("R3 normal ctx denied", 32'(rsp_fault), 1);
    cfg(2'd0, 32'h3);
    access(32'hFFFF_FFF0, 1'b1, 1'b0, 1'b0, 1'b1);
    check("R3 handler kept denied", 32'(rsp_fault), 1);

    // R4 reprogram one window, others untouched; R8 code 111
    cfg(2'd0, 32'h0);
    prog(9, 32'hFFFF_0000, 32'h0701_001F);
    cfg(2'd0, 32'h1);
    access(32'hFFFF_FFF0, 1'b0, 1'b0, 1'b0, 1'b0);
    check("R4 new window allow", 32'(rsp_allow), 1);
    check("R4 new window type", 32'(mtype()), 32'h01);
    access(32'hFFFF_FFF0, 1'b0, 1'b1, 1'b0, 1'b0);
    check("R8 code 111 write", 32'(rsp_allow), 0);
    access(32'h0000_1000, 1'b0, 1'b0, 1'b0, 1'b0);
    check("R4 window1 kept", 32'(mtype()), 32'h08);

    finish_run();
  end

endmodule